// File: doc/BRIEF.md
# Edge-Latching GPIO Input Interrupt Unit

This unit watches a small group of general-purpose input pins and turns their edges into a single level interrupt for a parent controller. Each pin is synchronised into the clock domain, then compared with its previous sample. Every rising transition sets a hidden rising flag for that pin, and every falling transition sets a hidden falling flag. Both flag sets record events at all times, whatever the pin's configuration.

Software reaches the unit through a byte-wide register port with a write strobe and a combinational read path. A trigger configuration register gives each pin a 2-bit selector. The selector decides which of the pin's two hidden flags shows up in the interrupt status register, and only the status bits that show can raise the parent line. Writing the status register with a 1 in a pin's bit clears both hidden flags of that pin, whatever trigger is selected at the time. Software can therefore build a both-edge scheme by clearing, then re-selecting, the trigger.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the configuration register reads 0x00, the status register reads 0x00 and `irq_o` is low.
- R2: The configuration register is at offset 3 and can be read and written. Pin i owns bits [2i+1:2i], and a value written there is read back unchanged.
- R3: A rising transition on a pin sets that pin's rising flag. When the pin's field is 2, status bit i (at offset 4) then reads 1.
- R4: A falling transition on a pin sets that pin's falling flag. When the pin's field is 1, status bit i then reads 1.
- R5: When a pin's field is 0 or 3, its status bit reads 0 and the pin does not drive `irq_o`, even with both of its flags set.
- R6: Both flags latch while the pin's field is 0. A flag latched that way shows up as soon as the field is changed to select it.
- R7: Writing offset 4 clears both flags of each pin whose written bit is 1 (write-one-to-clear). Pins written with 0 keep their flags.
- R8: If an edge is detected on a pin in the same cycle as a clear of that pin, the flag for that edge stays set.
- R9: `irq_o` is the OR of all visible status bits. It stays high until the visible flags are cleared or hidden.
- R10: Each input passes through a two-flop synchroniser. A pin change made before clock edge k shows in the status register after edge k+2 and not before.
- R11: Offsets other than 3 and 4 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous GPIO inputs |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Parent interrupt, level |

## Verification
A detected edge can land in the same cycle as a status clear for the same pin. The bench causes this on purpose: it changes the pin, counts the two synchroniser stages, and drives the clear strobe so that it samples on the exact edge where the edge detector fires. The flag must still be set afterwards, while a clear with no edge in that cycle must leave the status at zero. A sweep over every pin and every field value checks status and interrupt against a flag model kept in the bench.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CFG_OFS  = 3;
  localparam int unsigned STAT_OFS = 4;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_BAD  = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [NUM_PINS-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign pin_o = sync_q;

  // R10: output follows first stage one cycle later
  p_sync_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sync_q == $past(meta_q));
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] smp_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise_ev, fall_ev, rise_q, fall_q;
    assign rise_ev = smp_i[i] & ~prev_q[i];
    assign fall_ev = ~smp_i[i] & prev_q[i];

    // new edge beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        rise_q <= rise_ev | (rise_q & ~clr_i[i]);
        fall_q <= fall_ev | (fall_q & ~clr_i[i]);
      end
    end

    assign rise_o[i] = rise_q;
    assign fall_o[i] = fall_q;

    p_rise_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (smp_i[i] && !prev_q[i]) |=> rise_q);
    p_fall_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!smp_i[i] && prev_q[i]) |=> fall_q);
    p_clear_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && smp_i[i] == prev_q[i]) |=> (!rise_q && !fall_q));
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && rise_q) |=> rise_q);
  end
endmodule

// File: rtl/gpio_trig_mux.sv
module gpio_trig_mux
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic [2*NUM_PINS-1:0] cfg_i,
  input  logic [NUM_PINS-1:0]   rise_i,
  input  logic [NUM_PINS-1:0]   fall_i,
  output logic [NUM_PINS-1:0]   vis_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    trig_e sel;
    assign sel = trig_e'(cfg_i[2*i +: 2]);
    always_comb begin
      unique case (sel)
        TRIG_FALL: vis_o[i] = fall_i[i];
        TRIG_RISE: vis_o[i] = rise_i[i];
        default:   vis_o[i] = 1'b0; // off, and the invalid both-edge code
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  output logic                irq_o
);
  localparam int unsigned CFG_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] smp, rise, fall, vis, clr;
  logic [CFG_W-1:0]    cfg_q;
  logic                sel_cfg, sel_stat;

  assign sel_cfg  = (addr_i == ADDR_W'(CFG_OFS));
  assign sel_stat = (addr_i == ADDR_W'(STAT_OFS));

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .pin_o(smp)
  );

  gpio_edge_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .clr_i(clr),
    .rise_o(rise), .fall_o(fall)
  );

  gpio_trig_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .cfg_i(cfg_q), .rise_i(rise), .fall_i(fall), .vis_o(vis)
  );

  assign clr = (wr_i && sel_stat) ? wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cfg_q <= '0;
    else if (wr_i && sel_cfg) cfg_q <= wdata_i[CFG_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_cfg)       rdata_o[CFG_W-1:0]    = cfg_q;
    else if (sel_stat) rdata_o[NUM_PINS-1:0] = vis;
  end

  assign irq_o = |vis;

  p_cfg_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_cfg) |=> cfg_q == $past(wdata_i[CFG_W-1:0]));
  p_cfg_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_cfg) |=> $stable(cfg_q));
  p_irq_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q == '0) |-> !irq_o);
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rise != '0 || fall != '0));
endmodule

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin = '0;
  logic [2:0] addr = '0;
  logic wr = 0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [N-1:0] m_rise = '0, m_fall = '0;
  logic [7:0] m_cfg = '0;

  always #4 clk = ~clk;

  gpio_edge_irq dut (.clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wrt(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  function automatic logic [N-1:0] vis_exp();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      case (m_cfg[2*i +: 2])
        2'd1: v[i] = m_fall[i];
        2'd2: v[i] = m_rise[i];
        default: v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic move_pin(int p, logic v);
    pin[p] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (v) m_rise[p] = 1'b1; else m_fall[p] = 1'b1;
  endtask

  task automatic check_stat(string req);
    logic [7:0] d;
    logic [N-1:0] e;
    e = vis_exp();
    rd(3'd4, d);
    chk(req, d, {{(8-N){1'b0}}, e});
    chk(req, {7'd0, irq}, {7'd0, |e});
  endtask

  initial begin
    logic [7:0] d;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd3, d); chk("R1 cfg", d, 8'h00);
    rd(3'd4, d); chk("R1 stat", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 / R11 register access
    wrt(3'd3, 8'hA5); m_cfg = 8'hA5;
    rd(3'd3, d); chk("R2 rw", d, 8'hA5);
    wrt(3'd0, 8'hFF); wrt(3'd7, 8'h3C);
    rd(3'd3, d); chk("R11 cfg kept", d, 8'hA5);
    rd(3'd0, d); chk("R11 read zero", d, 8'h00);
    rd(3'd6, d); chk("R11 read zero", d, 8'h00);
    wrt(3'd3, 8'h00); m_cfg = 0;

    // Sweep: each pin, each field value
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        wrt(3'd4, 8'h0F); m_rise = 0; m_fall = 0;
        m_cfg = 8'(c) << (2*p);
        wrt(3'd3, m_cfg);
        move_pin(p, 1'b1);
        check_stat(c == 2 ? "R3 rise" : "R5 rise hidden");
        move_pin(p, 1'b0);
        check_stat(c == 1 ? "R4 fall" : "R5 both latched");
        // R7: clear other pins only, then this pin
        wrt(3'd4, 8'h0F & ~(8'd1 << p));
        check_stat("R7 zero-bit keeps");
        wrt(3'd4, 8'd1 << p); m_rise[p] = 0; m_fall[p] = 0;
        check_stat("R7 clear");
      end
    end

    // R6: latch under cfg 0, then reveal
    wrt(3'd3, 8'h00); m_cfg = 0;
    move_pin(2, 1'b1);
    check_stat("R6 hidden");
    wrt(3'd3, 8'h20); m_cfg = 8'h20;
    check_stat("R6 reveal rise");
    move_pin(2, 1'b0);
    wrt(3'd3, 8'h10); m_cfg = 8'h10;
    check_stat("R6 reveal fall");
    wrt(3'd3, 8'h30); m_cfg = 8'h30;
    check_stat("R5 code 3 off");

    // R9: multiple pins, irq holds until all cleared
    wrt(3'd4, 8'h0F); m_rise = 0; m_fall = 0;
    wrt(3'd3, 8'h8A); m_cfg = 8'h8A; // p0 rise, p1 rise, p3 rise
    move_pin(0, 1'b1); move_pin(3, 1'b1);
    check_stat("R9 two pins");
    wrt(3'd4, 8'h01); m_rise[0] = 0; m_fall[0] = 0;
    check_stat("R9 irq held");
    wrt(3'd4, 8'h08); m_rise[3] = 0; m_fall[3] = 0;
    check_stat("R9 irq drop");

    // R10 latency: not after 2 edges, visible after 3
    pin[1] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    rd(3'd4, d); chk("R10 early", d, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(3'd4, d); chk("R10 on time", d, 8'h02);
    m_rise[1] = 1;

    // R8: clear in same cycle as the edge detection
    wrt(3'd4, 8'h0F); m_rise = 0; m_fall = 0;
    pin[1] = 1'b0; // fall, hidden under rise select
    repeat (3) @(posedge clk); @(negedge clk);
    pin[1] = 1'b1;
    @(posedge clk); @(negedge clk);  // meta
    @(posedge clk); @(negedge clk);  // sync -> event this cycle
    addr = 3'd4; wdata = 8'h02; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
    rd(3'd4, d); chk("R8 edge wins", d, 8'h02);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    wrt(3'd4, 8'h02);
    rd(3'd4, d); chk("R8 later clear", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule